// File: doc/BRIEF.md
# Two-Core Write-Invalidate Snooping Cache System

The block connects two processor-side ports to one shared word-addressed memory. Each port has its own small direct-mapped cache of one-word lines, and both caches sit on a single shared bus. A core presents a request as a one-cycle pulse on its `req_i` bit. It then waits for a one-cycle `ack_o` pulse, which carries the read data and a flag that tells whether the cache already held the word. A read that finds its word stays local. A read miss fetches the word over the bus and fills the line.

Writes go through to memory. Every write also appears on the bus as an invalidate, whether or not the writer held the line. The peer cache snoops each bus write and drops any matching copy in the same edge, so its next read of that word misses and fetches the fresh value. A round-robin arbiter grants one bus transaction per cycle. This gives every write to a location one global order, and all caches end with the same value.

Top module: `snoop_coh_sys`

## Requirements
- R1: After reset, no `ack_o` bit is high, all cache lines are invalid and memory holds zero. The first read of any address therefore returns 0 with `hit_o` low.
- R2: A read whose line is invalid, or holds a different tag, takes a bus transaction. It returns the memory word with `hit_o` low and fills the line. `ack_o` is a single-cycle pulse in the cycle after the grant, and at the earliest two cycles after the request edge.
- R3: A read whose line is valid with a matching tag returns the cached word with `hit_o` high, without the bus, two cycles after the request edge.
- R4: Every write takes a bus transaction and updates memory in that transaction. `hit_o` reports whether the writer held the line. A write hit also updates the local line, so later local reads hit with the new word. For writes, `rdata_o` echoes the written word.
- R5: A write miss does not allocate, so the same core's next read of that address misses.
- R6: A bus write invalidates a peer line that holds the same address. The peer's next read misses and returns the written value.
- R7: A bus write leaves alone a peer line at the same index that holds a different tag. That line still hits with its old word.
- R8: Bus reads never invalidate peer copies. After both cores read the same word, both hit on it.
- R9: At most one controller is granted per cycle. When both need the bus in the same cycle, the one not granted most recently wins. The first contention after reset goes to core 0.
- R10: A local read hit in the same cycle as a peer write to that word returns the pre-write value with `hit_o` high. The reader's line is invalid afterwards.
- R11: Two writes to one address in the same cycle are serialized. Both cores then read the value of the write that completed later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | NC | Per-core request pulse, taken when that core has nothing outstanding |
| we_i | input | NC | Per-core write select (1 = write) |
| addr_i | input | NC*AW | Per-core word address, core c in bits [c*AW +: AW] |
| wdata_i | input | NC*DW | Per-core write word |
| ack_o | output | NC | Per-core one-cycle completion pulse |
| rdata_o | output | NC*DW | Per-core returned word, valid with ack |
| hit_o | output | NC | Per-core flag: request found its line in the cache |

## Verification
Two functions can fall in the same cycle: a core completing a read hit locally, and the peer's bus write snooping away that same line. The bench issues both requests on one edge, so that the reader's pending hit and the writer's grant coincide. It judges the result by the pre-write value returned with the hit flag, followed by a miss that returns the new word. Contention for the bus on one edge is provoked the same way, and it is judged by the relative ack cycles against a cycle-by-cycle behavioural model that runs through a long mixed-traffic phase.

// File: rtl/coh_pkg.sv
// Shared definitions for the snooping coherence system.
// Assumes: word-addressed memory, one-word cache lines.
package coh_pkg;
    typedef enum logic {
        BUS_READ  = 1'b0,
        BUS_WRITE = 1'b1
    } bus_op_e;
endpackage

// File: rtl/coh_arbiter.sv
// Round-robin bus arbiter: grants at most one requester per cycle,
// searching upward from the one after the last granted index.
// Assumes: NC >= 2; a grant lasts exactly one cycle (one transaction).
module coh_arbiter #(
    parameter int NC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NC-1:0] req,
    output logic [NC-1:0] gnt
);
    localparam int IXW = $clog2(NC);

    logic [IXW-1:0] last_q;
    logic [IXW-1:0] win_idx;

    // Rotating-priority search for the next requester.
    always_comb begin
        logic found;
        found   = 1'b0;
        gnt     = '0;
        win_idx = last_q;
        for (int k = 1; k <= NC; k++) begin
            int idx;
            idx = int'(last_q) + k;
            if (idx >= NC) idx = idx - NC;
            if (!found && req[idx]) begin
                found    = 1'b1;
                gnt[idx] = 1'b1;
                win_idx  = IXW'(idx);
            end
        end
    end

    // Remember the most recent winner; reset points at the last index so core 0 leads.
    always_ff @(posedge clk) begin
        if (!rst_n)    last_q <= IXW'(NC - 1);
        else if (|gnt) last_q <= win_idx;
    end
endmodule

// File: rtl/coh_memory.sv
// Backing memory: combinational read at the bus address, write at the
// clock edge of a bus write. Cleared to zero by reset.
// Assumes: one bus transaction per cycle.
module coh_memory #(
    parameter int AW = 5,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] mem_q [WORDS];

    // Write-through target: store bus writes, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
        end else if (wr_en) begin
            mem_q[addr] <= wdata;
        end
    end

    // Read port feeds fills in the same cycle as the bus read.
    assign rdata = mem_q[addr];
endmodule

// File: rtl/coh_cache_ctrl.sv
// Per-core cache controller: direct-mapped, one-word lines, write-through,
// no allocate on write. Serves read hits locally; puts read misses and all
// writes on the bus; snoops peer writes and invalidates a matching line.
// Assumes: the core issues one request and waits for ack before the next.
module coh_cache_ctrl
    import coh_pkg::*;
#(
    parameter int AW    = 5,
    parameter int DW    = 16,
    parameter int LINES = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          core_req,
    input  logic          core_we,
    input  logic [AW-1:0] core_addr,
    input  logic [DW-1:0] core_wdata,
    output logic          core_ack,
    output logic [DW-1:0] core_rdata,
    output logic          core_hit,
    output logic          bus_req,
    input  logic          bus_gnt,
    output bus_op_e       cmd_op,
    output logic [AW-1:0] cmd_addr,
    output logic [DW-1:0] cmd_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          snp_valid,
    input  bus_op_e       snp_op,
    input  logic [AW-1:0] snp_addr
);
    localparam int IW = $clog2(LINES);
    localparam int TW = AW - IW;

    logic          pend_q, we_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wd_q;
    logic [LINES-1:0] valid_q;
    logic [TW-1:0] tag_q  [LINES];
    logic [DW-1:0] data_q [LINES];

    logic [IW-1:0] idx, sidx;
    logic [TW-1:0] tg, stg;
    logic          hit, local_rd, snoop_kill;

    // Line lookup for the pending request and for the snooped address.
    always_comb begin
        idx        = addr_q[IW-1:0];
        tg         = addr_q[AW-1:IW];
        sidx       = snp_addr[IW-1:0];
        stg        = snp_addr[AW-1:IW];
        hit        = valid_q[idx] && (tag_q[idx] == tg);
        local_rd   = pend_q && !we_q && hit;
        bus_req    = pend_q && (we_q || !hit);
        snoop_kill = snp_valid && (snp_op == BUS_WRITE) && !bus_gnt &&
                     valid_q[sidx] && (tag_q[sidx] == stg);
    end

    assign cmd_op    = we_q ? BUS_WRITE : BUS_READ;
    assign cmd_addr  = addr_q;
    assign cmd_wdata = wd_q;

    // Request capture and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= 1'b0;
            we_q       <= 1'b0;
            addr_q     <= '0;
            wd_q       <= '0;
            core_ack   <= 1'b0;
            core_rdata <= '0;
            core_hit   <= 1'b0;
        end else begin
            core_ack <= 1'b0;
            if (local_rd) begin
                core_ack   <= 1'b1;
                core_rdata <= data_q[idx];
                core_hit   <= 1'b1;
                pend_q     <= 1'b0;
            end else if (bus_gnt) begin
                core_ack   <= 1'b1;
                core_rdata <= we_q ? wd_q : mem_rdata;
                core_hit   <= hit;
                pend_q     <= 1'b0;
            end
            if (!pend_q && core_req) begin
                pend_q <= 1'b1;
                we_q   <= core_we;
                addr_q <= core_addr;
                wd_q   <= core_wdata;
            end
        end
    end

    // Line contents: fill on granted read, update on granted write hit.
    always_ff @(posedge clk) begin
        if (bus_gnt && !we_q) begin
            tag_q[idx]  <= tg;
            data_q[idx] <= mem_rdata;
        end else if (bus_gnt && we_q && hit) begin
            data_q[idx] <= wd_q;
        end
    end

    // Valid bits: set by fills, cleared by reset or by a snooped peer write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            if (bus_gnt && !we_q) valid_q[idx]  <= 1'b1;
            if (snoop_kill)       valid_q[sidx] <= 1'b0;
        end
    end
endmodule

// File: rtl/snoop_coh_sys.sv
// Top level: NC cache controllers on one shared bus with a round-robin
// arbiter and a write-through backing memory. The granted controller
// drives the bus; every other controller snoops it in the same cycle.
// Assumes: per-core request/ack handshake, one request outstanding per core.
module snoop_coh_sys
    import coh_pkg::*;
#(
    parameter int NC    = 2,
    parameter int AW    = 5,
    parameter int DW    = 16,
    parameter int LINES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NC-1:0]    req_i,
    input  logic [NC-1:0]    we_i,
    input  logic [NC*AW-1:0] addr_i,
    input  logic [NC*DW-1:0] wdata_i,
    output logic [NC-1:0]    ack_o,
    output logic [NC*DW-1:0] rdata_o,
    output logic [NC-1:0]    hit_o
);
    logic [NC-1:0]    bus_req, bus_gnt;
    bus_op_e          cmd_op [NC];
    logic [NC*AW-1:0] cmd_addr;
    logic [NC*DW-1:0] cmd_wdata;
    logic             bus_valid;
    bus_op_e          bus_op;
    logic [AW-1:0]    bus_addr;
    logic [DW-1:0]    bus_wdata, mem_rdata;

    coh_arbiter #(.NC(NC)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(bus_req), .gnt(bus_gnt)
    );

    // Bus mux: the granted controller's command drives the shared bus.
    always_comb begin
        bus_op    = BUS_READ;
        bus_addr  = '0;
        bus_wdata = '0;
        for (int c = 0; c < NC; c++) begin
            if (bus_gnt[c]) begin
                bus_op    = cmd_op[c];
                bus_addr  = cmd_addr[c*AW +: AW];
                bus_wdata = cmd_wdata[c*DW +: DW];
            end
        end
    end
    assign bus_valid = |bus_gnt;

    coh_memory #(.AW(AW), .DW(DW)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .wr_en(bus_valid && (bus_op == BUS_WRITE)),
        .addr(bus_addr), .wdata(bus_wdata), .rdata(mem_rdata)
    );

    for (genvar c = 0; c < NC; c++) begin : g_ctrl
        coh_cache_ctrl #(.AW(AW), .DW(DW), .LINES(LINES)) u_ctrl (
            .clk(clk), .rst_n(rst_n),
            .core_req(req_i[c]), .core_we(we_i[c]),
            .core_addr(addr_i[c*AW +: AW]), .core_wdata(wdata_i[c*DW +: DW]),
            .core_ack(ack_o[c]), .core_rdata(rdata_o[c*DW +: DW]),
            .core_hit(hit_o[c]),
            .bus_req(bus_req[c]), .bus_gnt(bus_gnt[c]),
            .cmd_op(cmd_op[c]), .cmd_addr(cmd_addr[c*AW +: AW]),
            .cmd_wdata(cmd_wdata[c*DW +: DW]),
            .mem_rdata(mem_rdata),
            .snp_valid(bus_valid), .snp_op(bus_op), .snp_addr(bus_addr)
        );
    end
endmodule

// File: rtl/coh_checker.sv
// Protocol checker for snoop_coh_sys: arbitration and ack handshake.
// Assumes: NC >= 2.
module coh_checker #(
    parameter int NC = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NC-1:0] gnt,
    input logic [NC-1:0] breq,
    input logic [NC-1:0] ack
);
    // R9: never more than one bus owner per cycle.
    p_one_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    // R9: a grant only ever goes to a controller that asked.
    p_grant_needs_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~breq) == '0);

    // R9: after core 0 won, a waiting core 1 is next.
    p_rr_turn_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(gnt[0]) && breq[1]) |-> gnt[1]);

    for (genvar c = 0; c < NC; c++) begin : g_core
        // R2: a bus transaction completes with an ack on the next cycle.
        p_ack_after_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
            gnt[c] |=> ack[c]);
        // R2: the completion pulse lasts a single cycle.
        p_ack_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
            ack[c] |=> !ack[c]);
    end
endmodule

bind snoop_coh_sys coh_checker #(.NC(NC)) u_chk (
    .clk(clk), .rst_n(rst_n), .gnt(bus_gnt), .breq(bus_req), .ack(ack_o)
);

// File: tb/tb_snoop_coh_sys.sv
module tb_snoop_coh_sys;
    localparam int NC = 2, AW = 5, DW = 16, LINES = 8, WORDS = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NC-1:0]    req_i = '0, we_i = '0;
    logic [NC*AW-1:0] addr_i = '0;
    logic [NC*DW-1:0] wdata_i = '0;
    logic [NC-1:0]    ack_o, hit_o;
    logic [NC*DW-1:0] rdata_o;

    int checks = 0, fails = 0, cyc = 0;

    snoop_coh_sys #(.NC(NC), .AW(AW), .DW(DW), .LINES(LINES)) dut (.*);

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // Behavioural reference model, stepped once per clock edge.
    bit    m_pend [2], m_we [2], m_ack [2], m_hit [2];
    int    m_addr [2], m_wd [2], m_rd [2];
    string m_tag  [2];
    bit    cv [2][LINES];
    int    ct [2][LINES], cd [2][LINES];
    int    mem [WORDS];
    int    lg;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_pend[c] = 0; m_ack[c] = 0; m_hit[c] = 0; m_rd[c] = 0;
                for (int l = 0; l < LINES; l++) cv[c][l] = 0;
            end
            for (int w = 0; w < WORDS; w++) mem[w] = 0;
            lg = 1;
        end else begin
            bit old_p [2], h [2], need [2], na [2];
            int g;
            for (int c = 0; c < 2; c++) begin
                old_p[c] = m_pend[c];
                h[c]    = cv[c][m_addr[c] % LINES] && ct[c][m_addr[c] % LINES] == m_addr[c] / LINES;
                need[c] = m_pend[c] && (m_we[c] || !h[c]);
                na[c]   = 0;
            end
            g = -1;
            if (need[0] && need[1]) g = (lg == 0) ? 1 : 0;
            else if (need[0])       g = 0;
            else if (need[1])       g = 1;
            for (int c = 0; c < 2; c++) begin
                if (m_pend[c] && !m_we[c] && h[c]) begin
                    na[c] = 1; m_rd[c] = cd[c][m_addr[c] % LINES]; m_hit[c] = 1;
                    m_pend[c] = 0; m_tag[c] = "R3";
                end
            end
            if (g >= 0) begin
                int a, l, p;
                a = m_addr[g]; l = a % LINES; p = 1 - g;
                na[g] = 1; m_hit[g] = h[g]; m_pend[g] = 0; lg = g;
                if (m_we[g]) begin
                    mem[a] = m_wd[g]; m_rd[g] = m_wd[g]; m_tag[g] = "R4";
                    if (h[g]) cd[g][l] = m_wd[g];
                    if (cv[p][l] && ct[p][l] == a / LINES) cv[p][l] = 0;
                end else begin
                    m_rd[g] = mem[a]; m_tag[g] = "R2";
                    cv[g][l] = 1; ct[g][l] = a / LINES; cd[g][l] = mem[a];
                end
            end
            for (int c = 0; c < 2; c++) begin
                m_ack[c] = na[c];
                if (!old_p[c] && req_i[c]) begin
                    m_pend[c] = 1; m_we[c] = we_i[c];
                    m_addr[c] = int'(addr_i[c*AW +: AW]); m_wd[c] = int'(wdata_i[c*DW +: DW]);
                end
            end
        end
    end

    // Compare the design against the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int c = 0; c < 2; c++) begin
                chk(ack_o[c] == m_ack[c], "R2", "model ack", int'(ack_o[c]), int'(m_ack[c]));
                if (ack_o[c] && m_ack[c]) begin
                    chk(int'(rdata_o[c*DW +: DW]) == m_rd[c], m_tag[c], "model rdata",
                        int'(rdata_o[c*DW +: DW]), m_rd[c]);
                    chk(hit_o[c] == m_hit[c], m_tag[c], "model hit",
                        int'(hit_o[c]), int'(m_hit[c]));
                end
            end
        end
    end

    task automatic op(input int c, input bit we, input int a, input int wd,
                      output int rd, output bit hit, output int at);
        @(negedge clk);
        req_i[c] = 1'b1; we_i[c] = we;
        addr_i[c*AW +: AW] = AW'(a); wdata_i[c*DW +: DW] = DW'(wd);
        @(negedge clk);
        req_i[c] = 1'b0;
        while (!ack_o[c]) @(negedge clk);
        rd = int'(rdata_o[c*DW +: DW]); hit = hit_o[c]; at = cyc;
    endtask

    int  rd0, rd1, t0, t1;
    bit  h0, h1;

    initial begin
        #(10 * 150000);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ack_o == '0, "R1", "ack after reset", int'(ack_o), 0);

        // R1/R9: first contention after reset goes to core 0; reads miss and return 0
        fork
            op(0, 0, 1, 0, rd0, h0, t0);
            op(1, 0, 2, 0, rd1, h1, t1);
        join
        chk(rd0 == 0 && !h0, "R1", "core0 first read", rd0, 0);
        chk(rd1 == 0 && !h1, "R1", "core1 first read", rd1, 0);
        chk(t1 - t0 == 1, "R9", "core0 wins first contention", t1 - t0, 1);

        // R9: core1 last used the bus alone, so core0 wins the next clash
        op(1, 1, 20, 16'h0101, rd1, h1, t1);
        fork
            op(0, 1, 21, 16'h0202, rd0, h0, t0);
            op(1, 1, 22, 16'h0303, rd1, h1, t1);
        join
        chk(t1 - t0 == 1, "R9", "core0 wins after core1 turn", t1 - t0, 1);
        op(0, 1, 23, 16'h0404, rd0, h0, t0);
        fork
            op(0, 1, 24, 16'h0505, rd0, h0, t0);
            op(1, 1, 25, 16'h0606, rd1, h1, t1);
        join
        chk(t0 - t1 == 1, "R9", "core1 wins after core0 turn", t0 - t1, 1);

        // R6: the invalidate sequence on address 5
        op(0, 0, 5, 0, rd0, h0, t0);
        chk(rd0 == 0 && !h0, "R2", "A read X miss", rd0, 0);
        op(1, 0, 5, 0, rd1, h1, t1);
        chk(rd1 == 0 && !h1, "R2", "B read X miss", rd1, 0);
        op(0, 0, 5, 0, rd0, h0, t0);
        chk(h0 == 1, "R3", "A read X hit", int'(h0), 1);
        op(0, 1, 5, 1, rd0, h0, t0);
        chk(h0 == 1, "R4", "A write hit flag", int'(h0), 1);
        op(1, 0, 5, 0, rd1, h1, t1);
        chk(rd1 == 1 && !h1, "R6", "B read after invalidate", rd1, 1);
        op(0, 0, 5, 0, rd0, h0, t0);
        chk(rd0 == 1 && h0, "R4", "A local line updated", rd0, 1);

        // R5: write miss does not allocate
        op(1, 1, 12, 16'h0033, rd1, h1, t1);
        chk(!h1, "R5", "write miss flag", int'(h1), 0);
        op(1, 0, 12, 0, rd1, h1, t1);
        chk(rd1 == 16'h0033 && !h1, "R5", "read after write miss", int'(h1), 0);

        // R7: peer write to same index, other tag, keeps the line
        op(0, 1, 13, 16'h0099, rd0, h0, t0);
        op(1, 0, 5, 0, rd1, h1, t1);
        chk(rd1 == 1 && h1, "R7", "other-tag line kept", int'(h1), 1);

        // R8: bus reads do not invalidate
        op(0, 0, 7, 0, rd0, h0, t0);
        op(1, 0, 7, 0, rd1, h1, t1);
        op(0, 0, 7, 0, rd0, h0, t0);
        chk(h0 == 1, "R8", "copy survives peer read", int'(h0), 1);

        // R10: local hit and peer write on the same word in one cycle
        fork
            op(0, 0, 7, 0, rd0, h0, t0);
            op(1, 1, 7, 16'h0077, rd1, h1, t1);
        join
        chk(rd0 == 0 && h0, "R10", "hit returns pre-write value", rd0, 0);
        chk(t0 == t1, "R10", "hit and write same cycle", t0, t1);
        op(0, 0, 7, 0, rd0, h0, t0);
        chk(rd0 == 16'h0077 && !h0, "R10", "next read misses with new value", rd0, 16'h0077);

        // R11: simultaneous writes to one address are serialized
        fork
            op(0, 1, 9, 16'h000A, rd0, h0, t0);
            op(1, 1, 9, 16'h000B, rd1, h1, t1);
        join
        begin
            int fin;
            fin = (t0 > t1) ? 16'h000A : 16'h000B;
            fork
                op(0, 0, 9, 0, rd0, h0, t0);
                op(1, 0, 9, 0, rd1, h1, t1);
            join
            chk(rd0 == fin, "R11", "core0 final value", rd0, fin);
            chk(rd1 == fin, "R11", "core1 final value", rd1, fin);
        end

        // Mixed traffic against the model
        for (int i = 0; i < 1500; i++) begin
            fork
                begin
                    int r; bit h; int t;
                    repeat ($urandom % 3) @(negedge clk);
                    op(0, 1'($urandom % 2), int'(($urandom % 4) + 8 * ($urandom % 3)),
                       int'($urandom % 65536), r, h, t);
                end
                begin
                    int r; bit h; int t;
                    repeat ($urandom % 3) @(negedge clk);
                    op(1, 1'($urandom % 2), int'(($urandom % 4) + 8 * ($urandom % 3)),
                       int'($urandom % 65536), r, h, t);
                end
            join
        end

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule